// File: doc/BRIEF.md
# Cascadable Two-Digit BCD Counter with Seven-Segment Drive

This block keeps a two-digit decimal count, 00 to 99, and drives one seven-segment display per digit directly. It runs on a system clock. An external count input is brought into the clock domain through a two-flop synchronizer, and every rising edge found on it moves the count by one. The count goes up or down. Wraps roll over in decimal. Each wrap raises a carry/borrow output, so the output of one stage can feed the count input of the next.

The counting direction and the segment polarity are captured while reset is held. After that they stay fixed until the next reset. An active-low clear input returns the count to its starting value: 00 when counting up, 99 when counting down. Clear only acts once the input has stayed low for a programmable number of clock cycles, so short glitches on a slow clear line are rejected.

Top module: `dual_decade_seg_counter`

## Requirements
- R1: The direction input `dir_up_in` (1 = up, 0 = down) is captured while `rst` is high. Changes to it after reset have no effect on the counting direction.
- R2: The polarity input `pol_hi_in` is captured while `rst` is high. With 1 captured, a lit segment drives 1. With 0 captured, all fourteen segment outputs are inverted. Later changes to it are ignored.
- R3: Each rising edge of `count_in` moves the count by exactly one step, at most three clock cycles after the edge. The step is an increment in up mode and a decrement in down mode. The units digit rolls 9 to 0 going up (with the tens digit incremented) and 0 to 9 going down (with the tens digit decremented).
- R4: In up mode, a step from 99 gives 00. In down mode, a step from 00 gives 99.
- R5: `carry_out` goes to 1 on the step that wraps (R4). It returns to 0 on the next count step. It never rises on any other step.
- R6: `clear_n` is active low. After its synchronized level has been low for `CLR_CYCLES` consecutive clock cycles, the count goes to 00 in up mode or to 99 in down mode. A low pulse shorter than that leaves the count unchanged.
- R7: While clear is in effect, it overrides count edges: the count stays at the clear value. Clearing forces `carry_out` to 0 and never makes it rise.
- R8: After reset, the count equals the clear value for the captured direction, and `carry_out` is 0.
- R9: Segment vectors are ordered {g,f,e,d,c,b,a}, with g in bit 6. With active-high polarity, digits 0 to 9 give 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F and 0x6F. `seg_units` shows the right digit and `seg_tens` the left digit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; direction and polarity are captured while it is high |
| dir_up_in | input | 1 | Direction select: 1 counts up, 0 counts down |
| pol_hi_in | input | 1 | Polarity select: 1 means a lit segment drives high |
| count_in | input | 1 | Asynchronous count input; each rising edge gives one step |
| clear_n | input | 1 | Asynchronous active-low clear, qualified by a minimum low time |
| seg_units | output | 7 | Segments {g..a} of the right (units) digit |
| seg_tens | output | 7 | Segments {g..a} of the left (tens) digit |
| carry_out | output | 1 | Carry/borrow; rises once per wrap |

## Verification
Every state bit of the block can be seen on the segment pins or the carry pin within three clock cycles of the event that changes it. A stale or wrong digit therefore shows up as a wrong pattern on the first sample after a count pulse. A missed or doubled step leaves the tens/units pair off by one, and the error stays visible for every later step. A direction or polarity that leaks through after reset shows up as the wrong step direction or as all segments inverted. A clear qualifier that acts early or late shows up either on the count after a short pulse or on the count after a long one.

// File: rtl/ddc_pkg.sv
package ddc_pkg;

    localparam int unsigned DIGITS    = 2;
    localparam int unsigned SEG_W     = 7;
    localparam int unsigned DIGIT_MAX = 9;

    typedef logic [3:0]       digit_t;
    typedef logic [SEG_W-1:0] seg_t;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    typedef struct packed {
        digit_t tens;
        digit_t units;
    } count_t;

    typedef struct packed {
        dir_e dir;
        logic pol_hi;
    } mode_t;

    function automatic count_t clear_value(dir_e d);
        count_t c;
        if (d == DIR_UP) begin
            c.tens  = 4'd0;
            c.units = 4'd0;
        end else begin
            c.tens  = 4'(DIGIT_MAX);
            c.units = 4'(DIGIT_MAX);
        end
        return c;
    endfunction

    function automatic logic is_wrap(count_t c, dir_e d);
        if (d == DIR_UP)
            return (c.tens == 4'(DIGIT_MAX)) && (c.units == 4'(DIGIT_MAX));
        else
            return (c.tens == 4'd0) && (c.units == 4'd0);
    endfunction

    function automatic count_t bcd_step(count_t c, dir_e d);
        count_t n;
        n = c;
        if (d == DIR_UP) begin
            if (c.units == 4'(DIGIT_MAX)) begin
                n.units = 4'd0;
                n.tens  = (c.tens == 4'(DIGIT_MAX)) ? 4'd0 : c.tens + 4'd1;
            end else begin
                n.units = c.units + 4'd1;
            end
        end else begin
            if (c.units == 4'd0) begin
                n.units = 4'(DIGIT_MAX);
                n.tens  = (c.tens == 4'd0) ? 4'(DIGIT_MAX) : c.tens - 4'd1;
            end else begin
                n.units = c.units - 4'd1;
            end
        end
        return n;
    endfunction

    function automatic seg_t seg_pattern(digit_t v);
        case (v)
            4'd0:    return 7'h3F;
            4'd1:    return 7'h06;
            4'd2:    return 7'h5B;
            4'd3:    return 7'h4F;
            4'd4:    return 7'h66;
            4'd5:    return 7'h6D;
            4'd6:    return 7'h7D;
            4'd7:    return 7'h07;
            4'd8:    return 7'h7F;
            4'd9:    return 7'h6F;
            default: return 7'h00;
        endcase
    endfunction

endpackage

// File: rtl/ddc_sync.sv
module ddc_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst)
            chain_q <= {STAGES{RST_VAL}};
        else
            chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/ddc_count_edge.sv
module ddc_count_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic count_in,
    output logic step
);
    logic lvl;
    logic lvl_prev_q;

    ddc_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (count_in),
        .sync_out (lvl)
    );

    always_ff @(posedge clk) begin
        if (rst)
            lvl_prev_q <= 1'b0;
        else
            lvl_prev_q <= lvl;
    end

    assign step = lvl & ~lvl_prev_q;

    // R3
    one_step_chk: assert property (@(posedge clk) disable iff (rst)
        step |=> !step);
endmodule

// File: rtl/ddc_clear_qual.sv
module ddc_clear_qual #(
    parameter int unsigned STAGES     = 2,
    parameter int unsigned CLR_CYCLES = 50000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear_n,
    output logic clr_active
);
    localparam int unsigned CW = $clog2(CLR_CYCLES + 1);

    logic          clr_lvl_n;
    logic [CW-1:0] low_cnt_q;

    ddc_sync #(.STAGES(STAGES), .RST_VAL(1'b1)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (clear_n),
        .sync_out (clr_lvl_n)
    );

    always_ff @(posedge clk) begin
        if (rst || clr_lvl_n)
            low_cnt_q <= '0;
        else if (low_cnt_q < CW'(CLR_CYCLES))
            low_cnt_q <= low_cnt_q + 1'b1;
    end

    assign clr_active = (low_cnt_q == CW'(CLR_CYCLES));

    // R6
    clr_release_chk: assert property (@(posedge clk) disable iff (rst)
        clr_lvl_n |=> !clr_active);
endmodule

// File: rtl/ddc_bcd_core.sv
module ddc_bcd_core
    import ddc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  dir_e   dir,
    input  logic   step,
    input  logic   clr,
    output count_t count,
    output logic   carry
);
    count_t count_q;
    logic   carry_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= clear_value(dir);
            carry_q <= 1'b0;
        end else if (clr) begin
            count_q <= clear_value(dir);
            carry_q <= 1'b0;
        end else if (step) begin
            count_q <= bcd_step(count_q, dir);
            carry_q <= is_wrap(count_q, dir);
        end
    end

    assign count = count_q;
    assign carry = carry_q;

    // R4
    digit_range_chk: assert property (@(posedge clk) disable iff (rst)
        (count_q.units <= 4'd9) && (count_q.tens <= 4'd9));

    // R5
    carry_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(carry_q) |-> $past(step) && !$past(clr));

    // R7
    clear_hold_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count_q == clear_value(dir)) && !carry_q);

    // R3
    step_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!step && !clr) |=> $stable(count_q));
endmodule

// File: rtl/ddc_seg_decoder.sv
module ddc_seg_decoder
    import ddc_pkg::*;
(
    input  digit_t digit,
    input  logic   pol_hi,
    output seg_t   seg
);
    assign seg = seg_pattern(digit) ^ {SEG_W{~pol_hi}};
endmodule

// File: rtl/dual_decade_seg_counter.sv
module dual_decade_seg_counter
    import ddc_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned CLR_CYCLES  = 50000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       dir_up_in,
    input  logic       pol_hi_in,
    input  logic       count_in,
    input  logic       clear_n,
    output logic [6:0] seg_units,
    output logic [6:0] seg_tens,
    output logic       carry_out
);
    mode_t  mode_q;
    dir_e   dir_eff;
    logic   step;
    logic   clr_active;
    count_t count;
    digit_t digits [DIGITS];
    seg_t   segs   [DIGITS];

    // Mode is loaded on every reset cycle and frozen afterwards.
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q.dir    <= dir_e'(dir_up_in);
            mode_q.pol_hi <= pol_hi_in;
        end
    end

    assign dir_eff = rst ? dir_e'(dir_up_in) : mode_q.dir;

    ddc_count_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .count_in (count_in),
        .step     (step)
    );

    ddc_clear_qual #(.STAGES(SYNC_STAGES), .CLR_CYCLES(CLR_CYCLES)) u_clr (
        .clk        (clk),
        .rst        (rst),
        .clear_n    (clear_n),
        .clr_active (clr_active)
    );

    ddc_bcd_core u_core (
        .clk   (clk),
        .rst   (rst),
        .dir   (dir_eff),
        .step  (step),
        .clr   (clr_active),
        .count (count),
        .carry (carry_out)
    );

    assign digits[0] = count.units;
    assign digits[1] = count.tens;

    for (genvar i = 0; i < DIGITS; i++) begin : g_dec
        ddc_seg_decoder u_dec (
            .digit  (digits[i]),
            .pol_hi (mode_q.pol_hi),
            .seg    (segs[i])
        );
    end

    assign seg_units = segs[0];
    assign seg_tens  = segs[1];

    // R1
    dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(mode_q.dir));

    // R2
    pol_hold_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(mode_q.pol_hi));
endmodule

// File: tb/dual_decade_seg_counter_tb.sv
module dual_decade_seg_counter_tb;
    localparam int CLR = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dir_up_in = 1'b1;
    logic       pol_hi_in = 1'b1;
    logic       count_in = 1'b0;
    logic       clear_n = 1'b1;
    logic [6:0] seg_units, seg_tens;
    logic       carry_out;

    int checks = 0;
    int fails  = 0;
    int model  = 0;
    bit m_up   = 1'b1;
    bit m_pol  = 1'b1;
    bit m_cy   = 1'b0;

    always #10 clk = ~clk;

    dual_decade_seg_counter #(.CLR_CYCLES(CLR)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .dir_up_in (dir_up_in),
        .pol_hi_in (pol_hi_in),
        .count_in  (count_in),
        .clear_n   (clear_n),
        .seg_units (seg_units),
        .seg_tens  (seg_tens),
        .carry_out (carry_out)
    );

    function automatic logic [6:0] ref_seg(int d, bit pol);
        logic [6:0] p;
        case (d)
            0: p = 7'h3F; 1: p = 7'h06; 2: p = 7'h5B; 3: p = 7'h4F;
            4: p = 7'h66; 5: p = 7'h6D; 6: p = 7'h7D; 7: p = 7'h07;
            8: p = 7'h7F; default: p = 7'h6F;
        endcase
        return pol ? p : ~p;
    endfunction

    task automatic check(string req);
        logic [6:0] eu, et;
        eu = ref_seg(model % 10, m_pol);
        et = ref_seg(model / 10, m_pol);
        checks++;
        if (seg_units !== eu || seg_tens !== et || carry_out !== m_cy) begin
            fails++;
            $display("FAIL %s: got tens=%h units=%h carry=%b, expected tens=%h units=%h carry=%b",
                     req, seg_tens, seg_units, carry_out, et, eu, m_cy);
        end
    endtask

    task automatic do_reset(bit up, bit pol);
        @(negedge clk);
        dir_up_in = up; pol_hi_in = pol; rst = 1'b1;
        count_in = 1'b0; clear_n = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        m_up = up; m_pol = pol; m_cy = 1'b0;
        model = up ? 0 : 99;
    endtask

    task automatic pulse();
        count_in = 1'b1;
        repeat (3) @(negedge clk);
        count_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic step_model();
        if (m_up) begin
            m_cy = (model == 99);
            model = (model + 1) % 100;
        end else begin
            m_cy = (model == 0);
            model = (model + 99) % 100;
        end
    endtask

    // R8, R9: reset state with up direction and active-high segments
    task automatic t_reset_up();
        do_reset(1'b1, 1'b1);
        check("R8 reset up");
        checks++;
        if (seg_units !== 7'h3F) begin
            fails++;
            $display("FAIL R9: units=%h expected 3f", seg_units);
        end
    endtask

    // R3, R4, R5, R9: full up sweep including wrap and carry return
    task automatic t_up_sweep();
        for (int i = 0; i < 101; i++) begin
            pulse(); step_model();
            check("R3/R4/R5 up sweep");
        end
    endtask

    // R1, R2: inputs changed after reset have no effect
    task automatic t_mode_frozen();
        dir_up_in = 1'b0; pol_hi_in = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 polarity frozen");
        for (int i = 0; i < 3; i++) begin
            pulse(); step_model();
            check("R1 direction frozen");
        end
    endtask

    // R6, R7: short clear ignored, long clear to 00, priority over edges
    task automatic t_clear_up();
        clear_n = 1'b0;
        repeat (CLR - 6) @(negedge clk);
        clear_n = 1'b1;
        repeat (6) @(negedge clk);
        check("R6 short clear ignored");
        clear_n = 1'b0;
        repeat (CLR + 8) @(negedge clk);
        model = 0; m_cy = 1'b0;
        check("R6 long clear up");
        pulse(); pulse();
        check("R7 clear overrides count");
        clear_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R7 after clear release");
    endtask

    // R8, R2: reset with down direction and active-low segments
    task automatic t_reset_down();
        do_reset(1'b0, 1'b0);
        check("R8 reset down");
    endtask

    // R3, R4, R5: down sweep including borrow wrap
    task automatic t_down_sweep();
        for (int i = 0; i < 101; i++) begin
            pulse(); step_model();
            check("R3/R4/R5 down sweep");
        end
    endtask

    // R6, R7: carry set by a wrap is dropped by clear; down clears to 99
    task automatic t_clear_down();
        while (model != 0) begin pulse(); step_model(); end
        pulse(); step_model();
        check("R5 borrow high");
        clear_n = 1'b0;
        repeat (CLR + 8) @(negedge clk);
        model = 99; m_cy = 1'b0;
        check("R6 long clear down");
        clear_n = 1'b1;
        repeat (4) @(negedge clk);
        pulse(); step_model();
        check("R7 count after clear");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset_up();
        t_up_sweep();
        t_mode_frozen();
        t_clear_up();
        t_reset_down();
        t_down_sweep();
        t_clear_down();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule